// File: doc/BRIEF.md
# Self-Addressed Bus Loopback Interface

This block is the memory-control side of a shared control bus. The processor uses it to hand a 16-bit value to itself over the bus, so that the value can land in one of two registers that can only be loaded from the bus: the next-instruction register or the operand register. A microinstruction command picks the target register. The block latches the value from the internal data bus and builds an outgoing packet. The packet carries the block's own port number as both destination and source, and the no-operation code as its operation. The block then raises a bus request.

The packet goes onto the bus only in the cycle the external arbiter grants it. The block watches the bus at all times. It accepts a packet when three conditions hold: the packet is addressed to its own port, the packet's source equals the destination it stored, and a transfer is pending. It steers the packet's data into whichever register the pending flag names, then clears that flag. While a transfer is pending, further commands are ignored.

Top module: `self_loop_bus_if`

## Requirements
- R1: After reset, busy_o, req_o and bus_vld_o are 0, and nir_o and opnd_o are 0.
- R2: A command is accepted only while busy_o is 0, and only for code 2'b01 (next-instruction load) or code 2'b10 (operand load). In the cycle after an accepted command, busy_o and req_o are 1.
- R3: The bus outputs are all zero in every cycle in which no packet is being sent. A packet is sent in a cycle where grant_i is 1 and req_o is 1. In that cycle bus_vld_o is 1, bus_dst_o and bus_src_o equal port_id_i, bus_op_o is 4'h0 (no-operation), and bus_data_o is the ubus_i value latched with the command.
- R4: A transfer is sent on the bus exactly once. From the cycle after it is sent, req_o is 0, and later grants drive nothing.
- R5: An incoming packet is accepted when mon_vld_i is 1, mon_dst_i equals port_id_i, mon_src_i equals the stored destination, and a next-instruction transfer is pending. In the next cycle nir_o holds mon_data_i and busy_o is 0.
- R6: An operand transfer follows the same sequence, but the accepted data goes to opnd_o and nir_o is unchanged.
- R7: A packet whose destination or source does not match is ignored. busy_o stays 1, and nir_o and opnd_o are unchanged.
- R8: A command that arrives while busy_o is 1 is ignored. The data sent and captured is the value latched by the first command, and the target register is the one the first command chose.
- R9: A bus packet that arrives while no transfer is pending leaves nir_o and opnd_o unchanged.
- R10: Command codes 2'b00 and 2'b11 start nothing: busy_o and req_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Microinstruction memory-control command |
| ubus_i | input | 16 | Internal data bus value |
| port_id_i | input | 4 | Strapped own port number |
| grant_i | input | 1 | Single-cycle bus grant |
| req_o | output | 1 | Bus request |
| busy_o | output | 1 | Transfer pending |
| bus_vld_o | output | 1 | Outgoing packet strobe |
| bus_dst_o | output | 4 | Outgoing destination |
| bus_src_o | output | 4 | Outgoing source |
| bus_op_o | output | 4 | Outgoing operation code |
| bus_data_o | output | 16 | Outgoing data |
| mon_vld_i | input | 1 | Monitored packet strobe |
| mon_dst_i | input | 4 | Monitored destination |
| mon_src_i | input | 4 | Monitored source |
| mon_data_i | input | 16 | Monitored data |
| nir_o | output | 16 | Next-instruction register |
| opnd_o | output | 16 | Operand register |

## Verification
Every strap value from 0 to 15 is tried with both command kinds and two data patterns. This shows that the packet fields follow the strap and not a constant, and that the data reaches only the register the command chose. Returned packets with a wrong destination or a wrong source are sent first, then the correct one. This separates a full match from a match on only one field. Two other cases are tried: a second command inside a pending transfer, and packets on an idle bus. Both tell apart a design that ignores such input from one that relatches or captures it.

// File: rtl/slb_pkg.sv
package slb_pkg;
  localparam int PORT_W = 4;
  localparam int OP_W   = 4;
  localparam int DATA_W = 16;
  localparam logic [OP_W-1:0] OP_NOP = '0;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_NIR  = 2'b01,
    CMD_OPND = 2'b10,
    CMD_RSVD = 2'b11
  } mcu_cmd_e;

  typedef struct packed {
    logic [PORT_W-1:0] dst;
    logic [PORT_W-1:0] src;
    logic [OP_W-1:0]   op;
    logic [DATA_W-1:0] data;
  } bus_pkt_t;
endpackage

// File: rtl/slb_req_ctl.sv
module slb_req_ctl
  import slb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd_i,
  input  logic [DATA_W-1:0]   ubus_i,
  input  logic [PORT_W-1:0]   port_id_i,
  input  logic                sent_set_i,
  input  logic                capture_i,
  output logic                pend_nir_q,
  output logic                pend_opnd_q,
  output logic                req_q,
  output logic                sent_q,
  output bus_pkt_t            pkt_q
);
  logic     start;
  logic     pend_nir_d, pend_opnd_d, req_d, sent_d;
  bus_pkt_t pkt_d;

  always_comb begin
    start       = !(pend_nir_q || pend_opnd_q) &&
                  ((cmd_i == CMD_NIR) || (cmd_i == CMD_OPND));
    pend_nir_d  = pend_nir_q;
    pend_opnd_d = pend_opnd_q;
    req_d       = req_q;
    sent_d      = sent_q;
    pkt_d       = pkt_q;
    if (start) begin
      pend_nir_d  = (cmd_i == CMD_NIR);
      pend_opnd_d = (cmd_i == CMD_OPND);
      req_d       = 1'b1;
      sent_d      = 1'b0;
      pkt_d.dst   = port_id_i;
      pkt_d.src   = port_id_i;
      pkt_d.op    = OP_NOP;
      pkt_d.data  = ubus_i;
    end else if (capture_i) begin
      pend_nir_d  = 1'b0;
      pend_opnd_d = 1'b0;
      req_d       = 1'b0;
      sent_d      = 1'b0;
    end else if (sent_set_i) begin
      sent_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_nir_q  <= 1'b0;
      pend_opnd_q <= 1'b0;
      req_q       <= 1'b0;
      sent_q      <= 1'b0;
      pkt_q       <= '0;
    end else begin
      pend_nir_q  <= pend_nir_d;
      pend_opnd_q <= pend_opnd_d;
      req_q       <= req_d;
      sent_q      <= sent_d;
      if (start) pkt_q <= pkt_d;
    end
  end
endmodule

// File: rtl/slb_bus_drv.sv
module slb_bus_drv
  import slb_pkg::*;
(
  input  logic              grant_i,
  input  logic              req_q,
  input  logic              sent_q,
  input  bus_pkt_t          pkt_q,
  output logic              drive_o,
  output logic              bus_vld_o,
  output logic [PORT_W-1:0] bus_dst_o,
  output logic [PORT_W-1:0] bus_src_o,
  output logic [OP_W-1:0]   bus_op_o,
  output logic [DATA_W-1:0] bus_data_o
);
  always_comb begin
    drive_o    = grant_i && req_q && !sent_q;
    bus_vld_o  = drive_o;
    bus_dst_o  = drive_o ? pkt_q.dst  : '0;
    bus_src_o  = drive_o ? pkt_q.src  : '0;
    bus_op_o   = drive_o ? pkt_q.op   : '0;
    bus_data_o = drive_o ? pkt_q.data : '0;
  end
endmodule

// File: rtl/slb_rx_match.sv
module slb_rx_match
  import slb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_vld_i,
  input  logic [PORT_W-1:0] mon_dst_i,
  input  logic [PORT_W-1:0] mon_src_i,
  input  logic [DATA_W-1:0] mon_data_i,
  input  logic [PORT_W-1:0] port_id_i,
  input  logic [PORT_W-1:0] dst_q,
  input  logic              pend_nir_q,
  input  logic              pend_opnd_q,
  output logic              capture_o,
  output logic [DATA_W-1:0] nir_q,
  output logic [DATA_W-1:0] opnd_q
);
  logic to_me, from_expected, nir_en, opnd_en;

  always_comb begin
    to_me         = mon_vld_i && (mon_dst_i == port_id_i);
    from_expected = (mon_src_i == dst_q);
    capture_o     = to_me && from_expected && (pend_nir_q || pend_opnd_q);
    nir_en        = capture_o && pend_nir_q;
    opnd_en       = capture_o && pend_opnd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nir_q  <= '0;
      opnd_q <= '0;
    end else begin
      if (nir_en)  nir_q  <= mon_data_i;
      if (opnd_en) opnd_q <= mon_data_i;
    end
  end
endmodule

// File: rtl/self_loop_bus_if.sv
module self_loop_bus_if
  import slb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] ubus_i,
  input  logic [PORT_W-1:0] port_id_i,
  input  logic              grant_i,
  output logic              req_o,
  output logic              busy_o,
  output logic              bus_vld_o,
  output logic [PORT_W-1:0] bus_dst_o,
  output logic [PORT_W-1:0] bus_src_o,
  output logic [OP_W-1:0]   bus_op_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              mon_vld_i,
  input  logic [PORT_W-1:0] mon_dst_i,
  input  logic [PORT_W-1:0] mon_src_i,
  input  logic [DATA_W-1:0] mon_data_i,
  output logic [DATA_W-1:0] nir_o,
  output logic [DATA_W-1:0] opnd_o
);
  logic     pend_nir_q, pend_opnd_q, req_q, sent_q, drive, capture;
  bus_pkt_t pkt_q;

  slb_req_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .ubus_i     (ubus_i),
    .port_id_i  (port_id_i),
    .sent_set_i (drive),
    .capture_i  (capture),
    .pend_nir_q (pend_nir_q),
    .pend_opnd_q(pend_opnd_q),
    .req_q      (req_q),
    .sent_q     (sent_q),
    .pkt_q      (pkt_q)
  );

  slb_bus_drv u_drv (
    .grant_i   (grant_i),
    .req_q     (req_q),
    .sent_q    (sent_q),
    .pkt_q     (pkt_q),
    .drive_o   (drive),
    .bus_vld_o (bus_vld_o),
    .bus_dst_o (bus_dst_o),
    .bus_src_o (bus_src_o),
    .bus_op_o  (bus_op_o),
    .bus_data_o(bus_data_o)
  );

  slb_rx_match u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_vld_i  (mon_vld_i),
    .mon_dst_i  (mon_dst_i),
    .mon_src_i  (mon_src_i),
    .mon_data_i (mon_data_i),
    .port_id_i  (port_id_i),
    .dst_q      (pkt_q.dst),
    .pend_nir_q (pend_nir_q),
    .pend_opnd_q(pend_opnd_q),
    .capture_o  (capture),
    .nir_q      (nir_o),
    .opnd_q     (opnd_o)
  );

  assign req_o  = req_q && !sent_q;
  assign busy_o = pend_nir_q || pend_opnd_q;
endmodule

// File: rtl/slb_checker.sv
module slb_checker
  import slb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_i,
  input logic [PORT_W-1:0] port_id_i,
  input logic              grant_i,
  input logic              req_o,
  input logic              busy_o,
  input logic              bus_vld_o,
  input logic [PORT_W-1:0] bus_dst_o,
  input logic [PORT_W-1:0] bus_src_o,
  input logic [OP_W-1:0]   bus_op_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              mon_vld_i,
  input logic [PORT_W-1:0] mon_dst_i,
  input logic [PORT_W-1:0] mon_src_i,
  input logic [DATA_W-1:0] nir_o,
  input logic [DATA_W-1:0] opnd_o
);
  logic hit;
  assign hit = mon_vld_i && (mon_dst_i == port_id_i) && (mon_src_i == port_id_i);

  a_r2_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (cmd_i == CMD_NIR || cmd_i == CMD_OPND)) |=> (busy_o && req_o));

  a_r3_quiet_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_i |-> (!bus_vld_o && bus_data_o == '0 && bus_dst_o == '0 && bus_src_o == '0));

  a_r3_packet_fields: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld_o |-> (bus_dst_o == port_id_i && bus_src_o == port_id_i && bus_op_o == OP_NOP));

  a_r4_single_send: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld_o |=> !req_o);

  a_r5_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && hit) |=> !busy_o);

  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !hit) |=> busy_o);

  a_r9_idle_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ($stable(nir_o) && $stable(opnd_o)));

  a_r10_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (cmd_i == CMD_NONE || cmd_i == CMD_RSVD)) |=> !busy_o);
endmodule

bind self_loop_bus_if slb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .port_id_i(port_id_i),
  .grant_i(grant_i), .req_o(req_o), .busy_o(busy_o), .bus_vld_o(bus_vld_o),
  .bus_dst_o(bus_dst_o), .bus_src_o(bus_src_o), .bus_op_o(bus_op_o),
  .bus_data_o(bus_data_o), .mon_vld_i(mon_vld_i), .mon_dst_i(mon_dst_i),
  .mon_src_i(mon_src_i), .nir_o(nir_o), .opnd_o(opnd_o)
);

// File: tb/tb_self_loop_bus_if.sv
module tb_self_loop_bus_if;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cmd_i;
  logic [15:0] ubus_i;
  logic [3:0]  port_id_i;
  logic        grant_i;
  logic        req_o, busy_o, bus_vld_o;
  logic [3:0]  bus_dst_o, bus_src_o, bus_op_o;
  logic [15:0] bus_data_o;
  logic        mon_vld_i;
  logic [3:0]  mon_dst_i, mon_src_i;
  logic [15:0] mon_data_i;
  logic [15:0] nir_o, opnd_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [15:0] nir_exp = '0;
  logic [15:0] opnd_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  self_loop_bus_if dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ubus_i(ubus_i),
    .port_id_i(port_id_i), .grant_i(grant_i), .req_o(req_o), .busy_o(busy_o),
    .bus_vld_o(bus_vld_o), .bus_dst_o(bus_dst_o), .bus_src_o(bus_src_o),
    .bus_op_o(bus_op_o), .bus_data_o(bus_data_o), .mon_vld_i(mon_vld_i),
    .mon_dst_i(mon_dst_i), .mon_src_i(mon_src_i), .mon_data_i(mon_data_i),
    .nir_o(nir_o), .opnd_o(opnd_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic send_pkt(input logic [3:0] d, input logic [3:0] s, input logic [15:0] v);
    @(negedge clk);
    mon_vld_i = 1'b1; mon_dst_i = d; mon_src_i = s; mon_data_i = v;
    @(negedge clk);
    mon_vld_i = 1'b0; mon_dst_i = '0; mon_src_i = '0; mon_data_i = '0;
  endtask

  task automatic regs_chk(input string tag);
    chk({tag, " nir"}, {16'h0, nir_o}, {16'h0, nir_exp});
    chk({tag, " opnd"}, {16'h0, opnd_o}, {16'h0, opnd_exp});
  endtask

  task automatic transfer(input logic [3:0] port, input logic [1:0] cmd,
                          input logic [15:0] data, input bit extras);
    logic [15:0] junk;
    junk = ~data;
    @(negedge clk);
    port_id_i = port; cmd_i = cmd; ubus_i = data;
    @(negedge clk);
    cmd_i = 2'b00; ubus_i = 16'h0;
    chk("R2 busy", {31'h0, busy_o}, 32'h1);
    chk("R2 req", {31'h0, req_o}, 32'h1);
    chk("R3 idle bus", {15'h0, bus_vld_o, bus_data_o}, 32'h0);
    if (extras) begin
      cmd_i = (cmd == 2'b01) ? 2'b10 : 2'b01; ubus_i = junk;
      @(negedge clk);
      cmd_i = 2'b00; ubus_i = 16'h0;
      chk("R8 still busy", {31'h0, busy_o}, 32'h1);
    end
    grant_i = 1'b1;
    #1;
    chk("R3 vld", {31'h0, bus_vld_o}, 32'h1);
    chk("R3 dst", {28'h0, bus_dst_o}, {28'h0, port});
    chk("R3 src", {28'h0, bus_src_o}, {28'h0, port});
    chk("R3 op", {28'h0, bus_op_o}, 32'h0);
    chk("R3 R8 data", {16'h0, bus_data_o}, {16'h0, data});
    @(negedge clk);
    chk("R4 req low", {31'h0, req_o}, 32'h0);
    #1;
    chk("R4 no resend", {31'h0, bus_vld_o}, 32'h0);
    @(negedge clk);
    grant_i = 1'b0;
    if (extras) begin
      send_pkt(port ^ 4'h1, port, junk);
      chk("R7 dst mismatch busy", {31'h0, busy_o}, 32'h1);
      regs_chk("R7 dst mismatch");
      send_pkt(port, port ^ 4'h2, junk);
      chk("R7 src mismatch busy", {31'h0, busy_o}, 32'h1);
      regs_chk("R7 src mismatch");
    end
    send_pkt(port, port, data);
    if (cmd == 2'b01) nir_exp = data; else opnd_exp = data;
    chk("R5 busy clear", {31'h0, busy_o}, 32'h0);
    regs_chk(cmd == 2'b01 ? "R5 capture" : "R6 capture");
  endtask

  initial begin
    rst_n = 1'b0; cmd_i = '0; ubus_i = '0; port_id_i = 4'h1; grant_i = 1'b0;
    mon_vld_i = 1'b0; mon_dst_i = '0; mon_src_i = '0; mon_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'h0, busy_o}, 32'h0);
    chk("R1 req", {31'h0, req_o}, 32'h0);
    chk("R1 vld", {31'h0, bus_vld_o}, 32'h0);
    regs_chk("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 16; p++) begin
      for (int c = 1; c <= 2; c++) begin
        for (int k = 0; k < 2; k++) begin
          logic [15:0] d;
          d = (16'(p) * 16'h1111) ^ (k == 0 ? 16'hA5C3 : 16'h5A3C) ^ 16'(c << 8);
          transfer(4'(p), 2'(c), d, (k == 1));
        end
      end
    end

    for (int c = 0; c < 4; c += 3) begin
      @(negedge clk);
      cmd_i = 2'(c); ubus_i = 16'hBEEF;
      @(negedge clk);
      cmd_i = 2'b00;
      chk("R10 no busy", {31'h0, busy_o}, 32'h0);
      chk("R10 no req", {31'h0, req_o}, 32'h0);
    end

    for (int p = 0; p < 16; p++) begin
      port_id_i = 4'(p);
      send_pkt(4'(p), 4'(p), 16'hC0DE ^ 16'(p));
      regs_chk("R9 idle packet");
      chk("R9 idle busy", {31'h0, busy_o}, 32'h0);
    end

    finish_run();
  end
endmodule